// File: doc/BRIEF.md
# Snoop Address Parity Latch Checker

This block owns the single parity bit that travels with a line address on a memory bus. The line address is the set, tag and configurable-field bits placed side by side. When the local controller owns the bus, the block computes even parity over that address. It presents the parity through a latch that has its own latch-enable input, and it raises a drive-enable whenever the active-low output-enable is asserted. When another agent snoops, the pin is an input. The block then samples the parity supplied from outside, compares it with the even parity of the snooped address, and pulses an active-low error output when the two differ.

The sampling point follows a 2-bit timing-mode input, and the block runs entirely from one system clock. Synchronous mode treats the active-low snoop strobe as already aligned with the system clock. Clocked mode synchronizes both a separate snoop clock and the strobe, and samples on the first snoop-clock rise seen while the strobe is low. Strobed mode synchronizes the strobe and samples on its falling edge. Each strobe assertion is checked once at most. Outside that moment the parity input has no effect.

Top module: `addr_parity_guard`

## Requirements
- R1: While `addr_le` is 1, `par_out` equals the XOR of all bits of {`line_set`,`line_tag`,`line_cfa`}, so that the address bits and the parity bit together hold an even number of ones.
- R2: `par_drive` is 1 exactly when `addr_oe_n` is 0, and 0 when `addr_oe_n` is 1.
- R3: While `addr_le` is 0, `par_out` holds the parity computed on the last clock edge at which `addr_le` was 1 (0 after reset).
- R4: In synchronous mode (`snp_mode` = 0, and also the unused code 3), the comparison is made at the first clock edge at which `snp_stb_n` is sampled 0 after being sampled 1. The result appears on `perr_n` in the following cycle.
- R5: In clocked mode (`snp_mode` = 1), `snp_clk` and `snp_stb_n` each pass through two flops. The comparison is made once per strobe assertion, at the first clock edge where the synchronized snoop clock has just risen and the synchronized strobe is 0. Address and parity are sampled at that edge.
- R6: In strobed mode (`snp_mode` = 2), the comparison is made at the clock edge where the twice-synchronized strobe has just fallen. This is two edges after the raw strobe is first sampled 0.
- R7: While no comparison takes place, `par_in` and the address have no effect on `perr_n`. A strobe that stays low past its first check produces no further check.
- R8: A mismatch drives `perr_n` to 0 for exactly one clock cycle, the cycle after the sampling edge.
- R9: No error is reported for a sampling edge at which `addr_oe_n` is 0, because the block itself is then driving the bus.
- R10: A new `snp_mode` value takes effect only at an edge where both the raw strobe and the synchronized strobe are 1. A change made while a strobe is active is deferred until the strobe is released.
- R11: After reset, `perr_n` is 1, `par_out` is 0 while `addr_le` is 0, and the block is in synchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_set | input | SET_W | Set field of the line address |
| line_tag | input | TAG_W | Tag field of the line address |
| line_cfa | input | CFA_W | Configurable field of the line address |
| addr_le | input | 1 | Parity latch enable (transparent when 1) |
| addr_oe_n | input | 1 | Active-low output enable; 0 means the controller drives the bus |
| par_in | input | 1 | Parity received from the bus during snoops |
| par_out | output | 1 | Latched parity to be driven onto the bus |
| par_drive | output | 1 | Pad drive enable for the parity pin |
| snp_clk | input | 1 | Snoop clock used in clocked mode (asynchronous) |
| snp_stb_n | input | 1 | Active-low snoop strobe |
| snp_mode | input | 2 | Snoop timing mode: 0 synchronous, 1 clocked, 2 strobed, 3 as synchronous |
| perr_n | output | 1 | Active-low snoop parity error pulse |

## Verification
The checks assume that the snooping agent holds the line address and `par_in` steady for the whole time the strobe is low. In clocked and strobed mode the sample is taken several system clocks after the strobe falls. The stimulus therefore sets the address and parity together with the strobe and changes them only after the strobe has been high again for several cycles. The assertions also assume that the strobe stays high for at least one synchronized cycle between snoops, so that two sampling edges never fall on adjacent clocks. The bench inserts idle gaps of several cycles and uses a snoop clock whose period spans six system clocks.

// File: rtl/apg_pkg.sv
package apg_pkg;

    typedef enum logic [1:0] {
        SNP_SYNC    = 2'd0,
        SNP_CLOCKED = 2'd1,
        SNP_STROBED = 2'd2,
        SNP_SPARE   = 2'd3
    } snp_mode_e;

    typedef struct packed {
        logic held_par;
    } latch_state_t;

    typedef struct packed {
        snp_mode_e mode;
        logic      raw_prev_n;
        logic      done;
        logic      err;
    } check_state_t;

endpackage

// File: rtl/apg_parity_latch.sv
module apg_parity_latch
    import apg_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          le,
    input  logic          oe_n,
    output logic          par_out,
    output logic          par_drive
);

    latch_state_t st_d, st_q;
    logic         live_par;

    always_comb begin
        live_par = ^addr;
        st_d     = st_q;
        if (le) begin
            st_d.held_par = live_par;
        end
        par_out   = le ? live_par : st_q.held_par;
        par_drive = ~oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && $past(!le)) |-> $stable(par_out));

    // R2
    drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_drive != oe_n);

endmodule

// File: rtl/apg_snoop_sync.sv
module apg_snoop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_raw_n,
    input  logic sclk_raw,
    output logic stb_s_n,
    output logic stb_prev_n,
    output logic sclk_s,
    output logic sclk_prev
);

    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] stb;
        logic [DEPTH-1:0] sclk;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES < 1) begin : g_bad
            initial $error("STAGES must be at least 1");
        end
    endgenerate

    always_comb begin
        st_d.stb  = {st_q.stb[DEPTH-2:0], stb_raw_n};
        st_d.sclk = {st_q.sclk[DEPTH-2:0], sclk_raw};
        stb_s_n    = st_q.stb[STAGES-1];
        stb_prev_n = st_q.stb[STAGES];
        sclk_s     = st_q.sclk[STAGES-1];
        sclk_prev  = st_q.sclk[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stb  <= '1;
            st_q.sclk <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_s_n) |-> !stb_prev_n == 1'b0);

endmodule

// File: rtl/apg_snoop_check.sv
module apg_snoop_check
    import apg_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          par_in,
    input  logic          oe_n,
    input  logic [1:0]    mode_in,
    input  logic          stb_raw_n,
    input  logic          stb_s_n,
    input  logic          stb_prev_n,
    input  logic          sclk_s,
    input  logic          sclk_prev,
    output logic          perr_n
);

    check_state_t st_d, st_q;
    logic trig_sync, trig_strb, trig_clk, trig, fire, mismatch;

    always_comb begin
        trig_sync = ~stb_raw_n & st_q.raw_prev_n;
        trig_strb = ~stb_s_n & stb_prev_n;
        trig_clk  = sclk_s & ~sclk_prev & ~stb_s_n & ~st_q.done;

        unique case (st_q.mode)
            SNP_CLOCKED: trig = trig_clk;
            SNP_STROBED: trig = trig_strb;
            default:     trig = trig_sync;
        endcase

        fire     = trig & oe_n;
        mismatch = par_in ^ (^addr);

        st_d            = st_q;
        st_d.err        = fire & mismatch;
        st_d.raw_prev_n = stb_raw_n;
        if (stb_s_n) begin
            st_d.done = 1'b0;
        end else if (st_q.mode == SNP_CLOCKED && trig_clk) begin
            st_d.done = 1'b1;
        end
        if (stb_raw_n && stb_s_n) begin
            st_d.mode = snp_mode_e'(mode_in);
        end

        perr_n = ~st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode       <= SNP_SYNC;
            st_q.raw_prev_n <= 1'b1;
            st_q.done       <= 1'b0;
            st_q.err        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |=> perr_n);

    // R9
    no_own_cycle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(oe_n));

    // R10
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> ($past(stb_raw_n) && $past(stb_s_n)));

    // R7
    err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> ($past(!stb_raw_n) || $past(!stb_s_n)));

endmodule

// File: rtl/addr_parity_guard.sv
module addr_parity_guard
    import apg_pkg::*;
#(
    parameter int SET_W       = 8,
    parameter int TAG_W       = 12,
    parameter int CFA_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] line_set,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [CFA_W-1:0] line_cfa,
    input  logic             addr_le,
    input  logic             addr_oe_n,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_drive,
    input  logic             snp_clk,
    input  logic             snp_stb_n,
    input  logic [1:0]       snp_mode,
    output logic             perr_n
);

    localparam int AW = SET_W + TAG_W + CFA_W;

    logic [AW-1:0] line_addr;
    logic          stb_s_n, stb_prev_n, sclk_s, sclk_prev;

    assign line_addr = {line_set, line_tag, line_cfa};

    apg_parity_latch #(.AW(AW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (line_addr),
        .le        (addr_le),
        .oe_n      (addr_oe_n),
        .par_out   (par_out),
        .par_drive (par_drive)
    );

    apg_snoop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_raw_n  (snp_stb_n),
        .sclk_raw   (snp_clk),
        .stb_s_n    (stb_s_n),
        .stb_prev_n (stb_prev_n),
        .sclk_s     (sclk_s),
        .sclk_prev  (sclk_prev)
    );

    apg_snoop_check #(.AW(AW)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (line_addr),
        .par_in     (par_in),
        .oe_n       (addr_oe_n),
        .mode_in    (snp_mode),
        .stb_raw_n  (snp_stb_n),
        .stb_s_n    (stb_s_n),
        .stb_prev_n (stb_prev_n),
        .sclk_s     (sclk_s),
        .sclk_prev  (sclk_prev),
        .perr_n     (perr_n)
    );

    // R11
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> perr_n);

endmodule

// File: tb/sim_addr_parity_guard.sv
`timescale 1ns/1ps
module sim_addr_parity_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_set = '0;
    logic [11:0] line_tag = '0;
    logic [3:0]  line_cfa = '0;
    logic        addr_le = 1'b0;
    logic        addr_oe_n = 1'b1;
    logic        par_in = 1'b0;
    logic        snp_clk = 1'b0;
    logic        snp_stb_n = 1'b1;
    logic [1:0]  snp_mode = 2'd0;
    logic        par_out, par_drive, perr_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit run_chk = 0;
    bit r10_phase = 0;
    bit sclk_en = 0;

    always #5 clk = ~clk;

    addr_parity_guard u0 (
        .clk(clk), .rst_n(rst_n), .line_set(line_set), .line_tag(line_tag),
        .line_cfa(line_cfa), .addr_le(addr_le), .addr_oe_n(addr_oe_n),
        .par_in(par_in), .par_out(par_out), .par_drive(par_drive),
        .snp_clk(snp_clk), .snp_stb_n(snp_stb_n), .snp_mode(snp_mode),
        .perr_n(perr_n)
    );

    // behavioural reference model
    logic   stb_hist[$];
    logic   sclk_hist[$];
    int     m_mode;
    bit     m_done;
    logic   m_held;
    logic   exp_perr_n;
    logic   prev_exp_perr_n;
    string  exp_tag;

    task automatic model_reset();
        stb_hist = '{1'b1, 1'b1, 1'b1};
        sclk_hist = '{1'b0, 1'b0, 1'b0};
        m_mode = 0; m_done = 0; m_held = 1'b0;
        exp_perr_n = 1'b1; prev_exp_perr_n = 1'b1; exp_tag = "R11";
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit t_sync, t_strb, t_clk, t, bad;
            t_sync = !snp_stb_n && stb_hist[0];
            t_strb = !stb_hist[1] && stb_hist[2];
            t_clk  = sclk_hist[1] && !sclk_hist[2] && !stb_hist[1] && !m_done;
            t = (m_mode == 1) ? t_clk : (m_mode == 2) ? t_strb : t_sync;
            bad = (par_in != ^{line_set, line_tag, line_cfa});
            prev_exp_perr_n = exp_perr_n;
            exp_perr_n = !(t && addr_oe_n && bad);
            if (r10_phase) exp_tag = "R10";
            else if (t && addr_oe_n) exp_tag = (m_mode == 1) ? "R5" : (m_mode == 2) ? "R6" : "R4";
            else if (t) exp_tag = "R9";
            else if (!prev_exp_perr_n) exp_tag = "R8";
            else exp_tag = "R7";
            if (stb_hist[1]) m_done = 0;
            else if (m_mode == 1 && t_clk) m_done = 1;
            if (snp_stb_n && stb_hist[1]) m_mode = int'(snp_mode);
            if (addr_le) m_held = ^{line_set, line_tag, line_cfa};
            stb_hist.push_front(snp_stb_n);
            sclk_hist.push_front(snp_clk);
            void'(stb_hist.pop_back());
            void'(sclk_hist.pop_back());
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, 2 ns after the falling edge
    always begin
        @(negedge clk);
        #2;
        if (rst_n && run_chk) begin
            chk(exp_tag, perr_n, exp_perr_n);
            chk("R2", par_drive, !addr_oe_n);
            if (addr_le) chk("R1", par_out, ^{line_set, line_tag, line_cfa});
            else         chk("R3", par_out, m_held);
        end
    end

    // free-running snoop clock, six system clocks per period
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            if (sclk_en) snp_clk = ~snp_clk;
        end
    end

    task automatic rand_addr();
        line_set = 8'($urandom);
        line_tag = 12'($urandom);
        line_cfa = 4'($urandom);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            rand_addr();
            par_in = 1'($urandom);
            addr_le = 1'($urandom);
        end
    endtask

    task automatic snoop(bit good, int low_cycles, bit own);
        @(negedge clk);
        rand_addr();
        addr_le = 1'b0;
        addr_oe_n = !own;
        par_in = (^{line_set, line_tag, line_cfa}) ^ !good;
        snp_stb_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        snp_stb_n = 1'b1;
        addr_oe_n = 1'b1;
        repeat (4) @(negedge clk);
        idle(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R11", perr_n, 1'b1);
        chk("R11", par_out, 1'b0);
        chk("R11", par_drive, 1'b0);
        run_chk = 1;

        // controller-driven cycles: parity latch
        addr_oe_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rand_addr();
            addr_le = (i % 3 != 2);
        end
        addr_oe_n = 1'b1;
        idle(10);

        // synchronous mode
        for (int i = 0; i < 12; i++) snoop(i % 2 == 0, 1 + i % 3, 0);
        // own cycles with strobe low: no error
        for (int i = 0; i < 4; i++) snoop(0, 3, 1);

        // clocked mode
        @(negedge clk); snp_mode = 2'd1; sclk_en = 1;
        idle(4);
        for (int i = 0; i < 10; i++) snoop(i % 3 != 0, 14, 0);
        sclk_en = 0;
        idle(6);

        // strobed mode
        @(negedge clk); snp_mode = 2'd2;
        idle(4);
        for (int i = 0; i < 10; i++) snoop(i % 2 == 1, 2 + i % 4, 0);

        // spare code behaves as synchronous
        @(negedge clk); snp_mode = 2'd3;
        idle(4);
        for (int i = 0; i < 6; i++) snoop(i % 2 == 0, 2, 0);

        // R10: mode change while strobe low is deferred
        @(negedge clk); snp_mode = 2'd0;
        idle(4);
        r10_phase = 1;
        @(negedge clk);
        rand_addr();
        par_in = !(^{line_set, line_tag, line_cfa});
        snp_stb_n = 1'b0;
        @(negedge clk); snp_mode = 2'd2;
        repeat (5) @(negedge clk);
        snp_stb_n = 1'b1;
        repeat (5) @(negedge clk);
        r10_phase = 0;
        for (int i = 0; i < 4; i++) snoop(0, 3, 0);

        idle(8);
        run_chk = 0;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule